// File: doc/BRIEF.md
# Inertial Sensor Bring-Up Sequencer

This block powers up an inertial sensor through a simple register command port. A separate SPI master carries each command to the sensor. When `start_i` is pulsed, the sequencer runs the following steps in order:

1. It reads the identity register and compares the value with the expected identity.
2. It writes the soft-reset command and waits for the digital start-up time.
3. It writes one configuration word. The word combines the two bandwidth selects, the automatic self-test enable, the end-of-configuration bit and the self-test repetition count.
4. It waits a settling time that grows with the number of self-test repetitions.
5. It raises `done_o`.

All waits are counted in ticks of an external 1 µs timebase.

The sensor accepts the configuration register only once after each reset. For this reason, any change to a bandwidth select repeats the soft reset and the configuration write. The identity read is not repeated. A change that arrives while a sequence is running is latched and handled as soon as that sequence ends. A failed command stops the sequence in a fault state until the next start. An identity mismatch only sets a flag and does not stop the sequence. The delay lengths are parameters, so a simulation can use short waits.

Top module: `imu_bringup_seq`

## Requirements
- R1: After reset, `done_o`, `error_o`, `id_mismatch_o` and `cmd_req_o` are all 0.
- R2: A start taken while idle, done or faulted issues a read of address 0x00 as its first command. `id_mismatch_o` is set if the returned data differs from 0x0024. It is cleared by the next start. The sequence continues in either case.
- R3: The command after a successful identity read is a write of data 0x00B6 to address 0x2F.
- R4: The configuration request appears exactly `DIG_US` ticks after the soft-reset write is acknowledged.
- R5: The configuration write goes to address 0x0A, and its data bits are:
  - bit 0 = 1;
  - bit 1 = gyro select (1 for 50 Hz, 0 for 400 Hz);
  - bit 2 = accel select (same encoding);
  - bit 3 = 1;
  - bits 6:4 = `BIST_REPS`-1;
  - all other bits = 0.
- R6: `done_o` rises exactly `MECH_US + BIST_REPS*BIST_US + FLUSH_US` ticks after the configuration write is acknowledged.
- R7: While done, a change on either bandwidth select drops `done_o`. It then repeats the reset write and the configuration write (with the new bits), without an identity read.
- R8: A bandwidth change made after the configuration word has been fixed, during a running sequence, is serviced by one extra reset and configuration pass after the running sequence completes.
- R9: A command answered with `cmd_err_i` raises `error_o` on the next cycle. It drops `cmd_req_o`, keeps `done_o` low and issues no further command until a new start. That start runs the full sequence.
- R10: A start pulse during a running sequence is ignored: no extra command is issued.
- R11: While `cmd_req_o` is high and not yet answered, it stays high, and the address, direction and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that starts a full bring-up |
| gyro_slow_i | input | 1 | Gyro bandwidth select, 1 = 50 Hz, 0 = 400 Hz |
| accel_slow_i | input | 1 | Accel bandwidth select, 1 = 50 Hz, 0 = 400 Hz |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| cmd_req_o | output | 1 | Command request, held until acknowledged or failed |
| cmd_we_o | output | 1 | 1 = register write, 0 = register read |
| cmd_addr_o | output | 8 | Register address |
| cmd_wdata_o | output | 16 | Write data |
| cmd_ack_i | input | 1 | One-cycle pulse when the command completed |
| cmd_err_i | input | 1 | One-cycle pulse when the command failed |
| cmd_rdata_i | input | 16 | Read data, valid with `cmd_ack_i` |
| done_o | output | 1 | Sensor configured and settled |
| id_mismatch_o | output | 1 | Identity read returned an unexpected value |
| error_o | output | 1 | A command failed; waiting for start |

## Verification
The assertions assume that the command port answers only while a request is pending. They also assume that `cmd_ack_i` and `cmd_err_i` are single-cycle pulses that never arrive together, and that ticks are at least two clock cycles apart. The bench responder follows these rules: it answers a request after a random 1 to 3 cycle latency, always with a single pulse, and it drops its answer on the following cycle. The tick generator uses random spacing of 2 to 5 cycles. Because of that spacing, counting ticks between an acknowledge and the next port event gives exact delay lengths.

// File: rtl/imu_seq_pkg.sv
package imu_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID_RD,
    ST_RST_WR,
    ST_DIG_WAIT,
    ST_CFG_WR,
    ST_SETTLE,
    ST_DONE,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic gyro_slow;
    logic accel_slow;
  } bw_sel_t;

  localparam logic [7:0]  ADDR_IDENT  = 8'h00;
  localparam logic [7:0]  ADDR_CONFIG = 8'h0A;
  localparam logic [7:0]  ADDR_CMD    = 8'h2F;
  localparam logic [15:0] IDENT_VALUE = 16'h0024;
  localparam logic [15:0] SOFT_RESET  = 16'h00B6;

  // Configuration word: bit0 end-of-config, bit1 gyro bw, bit2 accel bw,
  // bit3 auto self-test, bits 6:4 repetitions minus one.
  function automatic logic [15:0] cfg_word(bw_sel_t bw, int unsigned reps);
    logic [15:0] w;
    w      = '0;
    w[0]   = 1'b1;
    w[1]   = bw.gyro_slow;
    w[2]   = bw.accel_slow;
    w[3]   = 1'b1;
    w[6:4] = 3'(reps - 1);
    return w;
  endfunction

  function automatic int unsigned settle_us(int unsigned mech, int unsigned bist,
                                            int unsigned flush, int unsigned reps);
    return mech + bist * reps + flush;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/imu_seq_timer.sv
module imu_seq_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/imu_seq_bwtrack.sv
module imu_seq_bwtrack
  import imu_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bw_sel_t sel_i,
  input  logic    capture_i,
  output bw_sel_t applied_o,
  output logic    pending_o
);
  bw_sel_t applied_q;
  logic    pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= '0;
      pending_q <= 1'b0;
    end else if (capture_i) begin
      applied_q <= sel_i;
      pending_q <= 1'b0;
    end else if (sel_i != applied_q) begin
      pending_q <= 1'b1;
    end
  end

  assign applied_o = applied_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/imu_bringup_seq.sv
module imu_bringup_seq
  import imu_seq_pkg::*;
#(
  parameter int unsigned BIST_REPS = 3,
  parameter int unsigned DIG_US    = 120000,
  parameter int unsigned MECH_US   = 100000,
  parameter int unsigned BIST_US   = 140000,
  parameter int unsigned FLUSH_US  = 60000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        gyro_slow_i,
  input  logic        accel_slow_i,
  input  logic        tick_us_i,
  output logic        cmd_req_o,
  output logic        cmd_we_o,
  output logic [7:0]  cmd_addr_o,
  output logic [15:0] cmd_wdata_o,
  input  logic        cmd_ack_i,
  input  logic        cmd_err_i,
  input  logic [15:0] cmd_rdata_i,
  output logic        done_o,
  output logic        id_mismatch_o,
  output logic        error_o
);
  localparam int unsigned SETTLE_US = settle_us(MECH_US, BIST_US, FLUSH_US, BIST_REPS);
  localparam int unsigned TMR_MAX   = max_u(SETTLE_US, DIG_US);
  localparam int          TMR_W     = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] DIG_LOAD    = TMR_W'(DIG_US);
  localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_US);

  seq_state_e state_q, state_d;
  bw_sel_t    sel, applied;
  logic       bw_pending;
  logic       tmr_expired;
  logic       idm_q;

  // named events for the checker
  logic start_ok, id_rd_ev, rst_ack_ev, cfg_ack_ev, cmd_fail_ev;
  logic dig_fire, settle_fire, rerun_ev, seq_busy;

  assign sel.gyro_slow  = gyro_slow_i;
  assign sel.accel_slow = accel_slow_i;

  assign start_ok    = start_i && (state_q == ST_IDLE || state_q == ST_DONE ||
                                   state_q == ST_FAULT);
  assign cmd_fail_ev = cmd_req_o && cmd_err_i;
  assign id_rd_ev    = (state_q == ST_ID_RD)  && cmd_ack_i && !cmd_err_i;
  assign rst_ack_ev  = (state_q == ST_RST_WR) && cmd_ack_i && !cmd_err_i;
  assign cfg_ack_ev  = (state_q == ST_CFG_WR) && cmd_ack_i && !cmd_err_i;
  assign dig_fire    = (state_q == ST_DIG_WAIT) && tmr_expired;
  assign settle_fire = (state_q == ST_SETTLE)   && tmr_expired;
  assign rerun_ev    = (state_q == ST_DONE) && !start_i && bw_pending;
  assign seq_busy    = !(state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAULT);

  imu_seq_bwtrack u_bw (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .capture_i (dig_fire),
    .applied_o (applied),
    .pending_o (bw_pending)
  );

  imu_seq_timer #(.W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (rst_ack_ev || cfg_ack_ev),
    .load_val_i (rst_ack_ev ? DIG_LOAD : SETTLE_LOAD),
    .tick_i     (tick_us_i),
    .expired_o  (tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FAULT: if (start_i) state_d = ST_ID_RD;
      ST_DONE: begin
        if (start_i)         state_d = ST_ID_RD;
        else if (bw_pending) state_d = ST_RST_WR;
      end
      ST_ID_RD: begin
        if (cmd_err_i)      state_d = ST_FAULT;
        else if (cmd_ack_i) state_d = ST_RST_WR;
      end
      ST_RST_WR: begin
        if (cmd_err_i)      state_d = ST_FAULT;
        else if (cmd_ack_i) state_d = ST_DIG_WAIT;
      end
      ST_DIG_WAIT: if (tmr_expired) state_d = ST_CFG_WR;
      ST_CFG_WR: begin
        if (cmd_err_i)      state_d = ST_FAULT;
        else if (cmd_ack_i) state_d = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_expired) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idm_q <= 1'b0;
    else if (start_ok) idm_q <= 1'b0;
    else if (id_rd_ev) idm_q <= (cmd_rdata_i != IDENT_VALUE);
  end

  always_comb begin
    cmd_req_o   = 1'b0;
    cmd_we_o    = 1'b0;
    cmd_addr_o  = '0;
    cmd_wdata_o = '0;
    unique case (state_q)
      ST_ID_RD: begin
        cmd_req_o  = 1'b1;
        cmd_addr_o = ADDR_IDENT;
      end
      ST_RST_WR: begin
        cmd_req_o   = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = ADDR_CMD;
        cmd_wdata_o = SOFT_RESET;
      end
      ST_CFG_WR: begin
        cmd_req_o   = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = ADDR_CONFIG;
        cmd_wdata_o = cfg_word(applied, BIST_REPS);
      end
      default: ;
    endcase
  end

  assign done_o        = (state_q == ST_DONE);
  assign error_o       = (state_q == ST_FAULT);
  assign id_mismatch_o = idm_q;
endmodule

// File: rtl/imu_seq_chk.sv
module imu_seq_chk #(
  parameter int unsigned BIST_REPS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_req_o,
  input logic        cmd_we_o,
  input logic [7:0]  cmd_addr_o,
  input logic [15:0] cmd_wdata_o,
  input logic        cmd_ack_i,
  input logic        cmd_err_i,
  input logic        done_o,
  input logic        error_o,
  input logic        id_rd_ev,
  input logic        settle_fire
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_ack_i && !cmd_err_i |=>
      cmd_req_o && $stable(cmd_addr_o) && $stable(cmd_we_o) && $stable(cmd_wdata_o));

  // R9
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && cmd_err_i |=> error_o && !cmd_req_o && !done_o);

  // R3
  reset_after_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd_ev |=> cmd_req_o && cmd_we_o && cmd_addr_o == 8'h2F && cmd_wdata_o == 16'h00B6);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(settle_fire));

  // R5
  cfg_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && cmd_addr_o == 8'h0A |->
      cmd_we_o && cmd_wdata_o[0] && cmd_wdata_o[3] &&
      cmd_wdata_o[6:4] == 3'(BIST_REPS - 1) && cmd_wdata_o[15:7] == '0);
endmodule

bind imu_bringup_seq imu_seq_chk #(.BIST_REPS(BIST_REPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_req_o   (cmd_req_o),
  .cmd_we_o    (cmd_we_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_wdata_o (cmd_wdata_o),
  .cmd_ack_i   (cmd_ack_i),
  .cmd_err_i   (cmd_err_i),
  .done_o      (done_o),
  .error_o     (error_o),
  .id_rd_ev    (id_rd_ev),
  .settle_fire (settle_fire)
);

// File: tb/imu_bringup_seq_tb_top.sv
module imu_bringup_seq_tb_top;
  localparam int DIG = 9, MECH = 4, BISTU = 6, FLUSH = 3, REPS = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, gs = 1'b0, as_ = 1'b0, tick = 1'b0;
  logic ack = 1'b0, err = 1'b0;
  logic [15:0] rdata = '0;
  wire req, we, done, idm, error;
  wire [7:0] addr;
  wire [15:0] wdata;

  imu_bringup_seq #(.BIST_REPS(REPS), .DIG_US(DIG), .MECH_US(MECH),
                    .BIST_US(BISTU), .FLUSH_US(FLUSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .gyro_slow_i(gs),
    .accel_slow_i(as_), .tick_us_i(tick), .cmd_req_o(req), .cmd_we_o(we),
    .cmd_addr_o(addr), .cmd_wdata_o(wdata), .cmd_ack_i(ack), .cmd_err_i(err),
    .cmd_rdata_i(rdata), .done_o(done), .id_mismatch_o(idm), .error_o(error));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  int log_n = 0;
  logic [7:0]  lg_addr [64];
  logic        lg_we   [64];
  logic [15:0] lg_data [64];
  int          lg_gap  [64];
  int since_ack = 0, settle_gap = -1, wait_cnt = 0, lat = 1;
  int tick_cnt = 0, tick_gap = 3, err_addr = -1;
  bit bad_id = 0;
  logic done_q = 1'b0;

  function automatic logic [15:0] exp_cfg(bit g, bit a);
    return 16'h0009 | (g ? 16'h0002 : 16'h0000) | (a ? 16'h0004 : 16'h0000)
           | (16'(REPS - 1) << 4);
  endfunction
  localparam int EXP_SETTLE = MECH + FLUSH + REPS * BISTU;

  // command-port responder, tick generator and timing monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_q) settle_gap = since_ack;
      done_q = done;
      if (req && !ack && !err && wait_cnt == 0 && log_n < 64) lg_gap[log_n] = since_ack;
      tick_cnt++;
      if (tick_cnt >= tick_gap) begin
        tick = 1'b1; since_ack++; tick_cnt = 0; tick_gap = 2 + int'($urandom % 4);
      end else tick = 1'b0;
      if (ack || err) begin
        ack = 1'b0; err = 1'b0; wait_cnt = 0;
      end else if (req) begin
        if (wait_cnt == 0) lat = 1 + int'($urandom % 3);
        wait_cnt++;
        if (wait_cnt > lat) begin
          if (err_addr == int'(addr)) begin
            err = 1'b1; err_addr = -1;
          end else begin
            ack = 1'b1;
            rdata = bad_id ? 16'h0042 : 16'h0024;
            if (log_n < 64) begin
              lg_addr[log_n] = addr; lg_we[log_n] = we; lg_data[log_n] = wdata;
            end
            log_n++;
          end
          since_ack = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, act, act, exp, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int i;
    for (i = 0; i < 4000; i++) begin
      if (log_n >= n && done) break;
      step();
    end
    chk(i < 4000, "R6 completion", log_n, n);
  endtask

  task automatic wait_log(input int n);
    int i;
    for (i = 0; i < 4000; i++) begin
      if (log_n >= n) break;
      step();
    end
    chk(i < 4000, "R2 command progress", log_n, n);
  endtask

  task automatic check_run(input int base, input bit g, input bit a, input bit full, input bit bad);
    int k;
    k = base;
    if (full) begin
      chk(lg_addr[k] == 8'h00 && !lg_we[k], "R2 identity read first", int'(lg_addr[k]), 0);
      k++;
      chk(idm == bad, "R2 mismatch flag", int'(idm), int'(bad));
    end
    chk(lg_addr[k] == 8'h2F && lg_we[k] && lg_data[k] == 16'h00B6, "R3 soft reset write",
        int'(lg_data[k]), 16'h00B6);
    k++;
    chk(lg_gap[k] == DIG, "R4 start-up delay ticks", lg_gap[k], DIG);
    chk(lg_addr[k] == 8'h0A && lg_we[k] && lg_data[k] == exp_cfg(g, a), "R5 config word",
        int'(lg_data[k]), int'(exp_cfg(g, a)));
    chk(settle_gap == EXP_SETTLE, "R6 settle ticks", settle_gap, EXP_SETTLE);
    chk(log_n == k + 1, "R2 command count", log_n, k + 1);
  endtask

  initial begin
    int base;
    void'($urandom(32'h1234ABCD));
    repeat (3) step();
    chk(!done && !error && !idm && !req, "R1 reset outputs", {done, error, idm, req}, 0);
    rst_n = 1'b1;
    step();

    // default bandwidth, good identity
    base = log_n; settle_gap = -1;
    pulse_start(); wait_done(base + 3); check_run(base, 0, 0, 1, 0);

    // wrong identity: flag only, sequence completes
    bad_id = 1; base = log_n; settle_gap = -1;
    pulse_start(); wait_done(base + 3); check_run(base, 0, 0, 1, 1);
    bad_id = 0;

    // R7 change while done
    base = log_n; settle_gap = -1; gs = 1'b1;
    repeat (3) step();
    chk(!done, "R7 done drops on change", int'(done), 0);
    wait_done(base + 2); check_run(base, 1, 0, 0, 1);

    // R8 change after config fixed
    base = log_n; settle_gap = -1;
    pulse_start(); wait_log(base + 3);
    as_ = 1'b1;
    wait_done(base + 5);
    chk(lg_addr[base+3] == 8'h2F && lg_data[base+4] == exp_cfg(1, 1), "R8 rerun config",
        int'(lg_data[base+4]), int'(exp_cfg(1, 1)));
    chk(lg_addr[base+4] == 8'h0A, "R8 rerun address", int'(lg_addr[base+4]), 8'h0A);
    repeat (60) step();
    chk(log_n == base + 5 && done, "R8 single rerun", log_n, base + 5);

    // R9 command error on reset write
    base = log_n; err_addr = 8'h2F;
    pulse_start();
    for (int i = 0; i < 200 && !error; i++) step();
    chk(error && !done, "R9 fault flag", int'(error), 1);
    repeat (20) step();
    chk(!req && log_n == base + 1 && error, "R9 no further commands", log_n, base + 1);
    base = log_n; settle_gap = -1;
    pulse_start();
    chk(!error, "R9 start clears fault", int'(error), 0);
    wait_done(base + 3); check_run(base, 1, 1, 1, 0);

    // R10 start while busy
    base = log_n; settle_gap = -1;
    pulse_start(); wait_log(base + 2); pulse_start();
    wait_done(base + 3);
    repeat (40) step();
    chk(log_n == base + 3 && done, "R10 busy start ignored", log_n, base + 3);

    // constrained random runs
    for (int it = 0; it < 6; it++) begin
      bit g, a, b;
      g = 1'($urandom % 2); a = 1'($urandom % 2); b = 1'($urandom % 2);
      base = log_n; settle_gap = -1;
      gs = g; as_ = a; bad_id = b;
      pulse_start(); wait_done(base + 3); check_run(base, g, a, 1, b);
      if (log_n > 56) break;
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule